// File: doc/BRIEF.md
# Dual-Mode Timer with Time-Base Option

An 8-bit up-counter with two count sources. In interval mode it advances on one-cycle pulses from one of four system-clock prescaler taps. In time-base mode it follows a slow, asynchronous subclock. The subclock is brought into the system-clock domain and divided by an internal prescaler. The prescaler tap then sets one of four counter overflow periods. A sticky flag records each wrap from all-ones to zero, and software clears it with a one-cycle strobe.

A single write port loads the control fields: source select, a self-clearing clear request and a two-bit period select. A power-mode input decides, for each source, whether the counter advances or holds its value. No data stream passes through the block, so it has no valid/ready handshake. Every pin is a plain control or status level or a one-cycle strobe, and it never back-pressures the writer.

Top module: `dual_timebase_timer`

## Requirements
- R1: After reset `count` is 0 and `ovf_flag` is 0. The control fields reset to interval mode with select 00, so a pulse on `sys_ticks[0]` advances the counter.
- R2: In interval mode (control bit 3 = 0), the counter advances by one for each cycle in which `sys_ticks[sel]` is high, where sel is control bits [1:0]. Pulses on the other taps are ignored.
- R3: In time-base mode (control bit 3 = 1), the counter advances once every 2^k subclock rising edges after a clear or a reset. k is 7, 6, 5 or 2 for select 00, 01, 10 or 11. With a 32.768 kHz subclock this gives overflow periods of 1 s, 0.5 s, 0.25 s and 31.25 ms.
- R4: Each subclock rising edge passes through a two-flop synchronizer and an edge detector. It yields exactly one prescaler step, however long the subclock stays high.
- R5: A write with bits 3 and 2 both set clears the counter and the time-base prescaler to zero in that cycle. Bit 2 is not stored.
- R6: A write with bit 2 set and bit 3 clear leaves the counter value unchanged.
- R7: A counter wrap from 0xFF to 0x00 sets `ovf_flag`. The flag stays set until a `flag_clr` pulse. If a wrap and a clear pulse fall in the same cycle, the flag is set.
- R8: `pwr_mode` encodes 0 active, 1 sleep, 2 watch, 3 subactive, 4 subsleep and 5 standby. In interval mode the counter advances only in modes 0 and 1 and holds its value in the others.
- R9: In time-base mode the counter advances in modes 0 to 4. In standby (5) both the counter and the time-base prescaler hold their values.
- R10: The counter only ever steps by +1, wraps to 0, or is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_wdata | input | 4 | Control data: [3] source, [2] clear request, [1:0] select |
| sys_ticks | input | 4 | One-cycle pulses from the system-clock prescaler taps |
| sub_clk | input | 1 | Asynchronous low-frequency subclock |
| pwr_mode | input | 3 | Power mode, encoded as in R8 |
| flag_clr | input | 1 | Write-1 strobe that clears the overflow flag |
| count | output | 8 | Counter value |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bound checker checks on every cycle that the counter moves only by single steps, wraps or clears. It also checks that it holds while counting is barred by the power mode, and that a wrap sets the flag, which then stays set until cleared. The divide ratio for each select value, the single step per subclock edge for long pulses, and the tap-select behaviour can only be shown by the bench's sweeps. The same goes for the prescaler freeze in standby and the effect of clear writes, because each of these depends on a count of events.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
  typedef enum logic [2:0] {
    PM_RUN     = 3'd0,
    PM_DOZE    = 3'd1,
    PM_WATCH   = 3'd2,
    PM_SUBRUN  = 3'd3,
    PM_SUBDOZE = 3'd4,
    PM_STANDBY = 3'd5
  } pmode_e;

  localparam int CFG_W   = 4;
  localparam int CFG_SRC = 3;
  localparam int CFG_CLR = 2;
  localparam int SEL_W   = 2;
  localparam int N_TAPS  = 1 << SEL_W;

  function automatic logic iv_may_count(logic [2:0] pm);
    return (pm == PM_RUN) || (pm == PM_DOZE);
  endfunction

  function automatic logic tb_may_count(logic [2:0] pm);
    return pm <= PM_SUBDOZE;
  endfunction
endpackage

// File: rtl/dtt_sync_edge.sv
module dtt_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/dtt_prescaler.sv
module dtt_prescaler #(
  parameter int unsigned K0 = 7,
  parameter int unsigned K1 = 6,
  parameter int unsigned K2 = 5,
  parameter int unsigned K3 = 2,
  parameter int unsigned PSC_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       adv,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int unsigned KS [4] = '{K0, K1, K2, K3};

  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] masks [4];
  logic [PSC_W-1:0] mask;

  for (genvar g = 0; g < 4; g++) begin : g_mask
    assign masks[g] = PSC_W'((1 << KS[g]) - 1);
  end

  assign mask = masks[sel];
  assign tick = adv && ((psc_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   psc_q <= '0;
    else if (clr) psc_q <= '0;
    else if (adv) psc_q <= psc_q + 1'b1;
  end
endmodule

// File: rtl/dtt_counter.sv
module dtt_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic         flag_clr,
  output logic [W-1:0] count,
  output logic         flag
);
  logic wrap;

  assign wrap = inc && !clr && (count == {W{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      flag  <= 1'b0;
    end else begin
      if (clr)      count <= '0;
      else if (inc) count <= count + 1'b1;
      if (wrap)          flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_timebase_timer.sv
module dual_timebase_timer #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned K0 = 7,
  parameter int unsigned K1 = 6,
  parameter int unsigned K2 = 5,
  parameter int unsigned K3 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_wdata,
  input  logic [3:0]       sys_ticks,
  input  logic             sub_clk,
  input  logic [2:0]       pwr_mode,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag
);
  import dtt_pkg::*;

  localparam int unsigned PSC_W = (K0 > K1 ? K0 : K1) > (K2 > K3 ? K2 : K3)
                                ? (K0 > K1 ? K0 : K1) : (K2 > K3 ? K2 : K3);

  logic             src_q;
  logic [SEL_W-1:0] sel_q;
  logic             clr_req;
  logic             sub_rise;
  logic             tb_run, iv_run;
  logic             tb_tick;
  logic             inc;

  assign clr_req = cfg_we && cfg_wdata[CFG_CLR] && cfg_wdata[CFG_SRC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      sel_q <= '0;
    end else if (cfg_we) begin
      src_q <= cfg_wdata[CFG_SRC];
      sel_q <= cfg_wdata[SEL_W-1:0];
    end
  end

  assign tb_run = tb_may_count(pwr_mode);
  assign iv_run = iv_may_count(pwr_mode);

  dtt_sync_edge u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (sub_clk),
    .rise     (sub_rise)
  );

  dtt_prescaler #(
    .K0(K0), .K1(K1), .K2(K2), .K3(K3), .PSC_W(PSC_W)
  ) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_req),
    .adv   (sub_rise && tb_run),
    .sel   (sel_q),
    .tick  (tb_tick)
  );

  assign inc = src_q ? tb_tick : (sys_ticks[sel_q] && iv_run);

  dtt_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_req),
    .inc      (inc),
    .flag_clr (flag_clr),
    .count    (count),
    .flag     (ovf_flag)
  );
endmodule

// File: rtl/dtt_checker.sv
module dtt_checker #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_we,
  input logic [3:0]   cfg_wdata,
  input logic [2:0]   pwr_mode,
  input logic         flag_clr,
  input logic [W-1:0] count,
  input logic         ovf_flag,
  input logic         src_q
);
  logic clr_w;
  assign clr_w = cfg_we && cfg_wdata[3] && cfg_wdata[2];

  p_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> ((count == W'($past(count) + 1'b1)) || (count == '0)));

  p_standby_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 3'd5 && !clr_w) |=> $stable(count));

  p_interval_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_q && pwr_mode >= 3'd2 && !clr_w) |=> $stable(count));

  p_wrap_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(count) == {W{1'b1}} && count == '0 && !$past(clr_w)) |-> ovf_flag);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag);
endmodule

bind dual_timebase_timer dtt_checker #(.W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .pwr_mode  (pwr_mode),
  .flag_clr  (flag_clr),
  .count     (count),
  .ovf_flag  (ovf_flag),
  .src_q     (src_q)
);

// File: tb/dual_timebase_timer_test.sv
`timescale 1ns/1ps
module dual_timebase_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_wdata = '0;
  logic [3:0] sys_ticks = '0;
  logic       sub_clk = 1'b0;
  logic [2:0] pwr_mode = '0;
  logic       flag_clr = 1'b0;
  logic [7:0] count;
  logic       ovf_flag;
  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  dual_timebase_timer uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .sys_ticks(sys_ticks), .sub_clk(sub_clk), .pwr_mode(pwr_mode),
    .flag_clr(flag_clr), .count(count), .ovf_flag(ovf_flag)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cfg_we = 0; sys_ticks = 0; sub_clk = 0; pwr_mode = 0; flag_clr = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input bit src, input bit clr, input int sel);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = {src, clr, 2'(sel)};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse(input int tap, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sys_ticks = 4'(1 << tap);
      @(negedge clk); sys_ticks = '0;
    end
  endtask

  task automatic subs(input int n, input int half);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sub_clk = 1'b1;
      repeat (half) @(negedge clk);
      sub_clk = 1'b0;
      repeat (half) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 count", count, 0);
    chk("R1 flag", ovf_flag, 0);
    pulse(0, 1);
    chk("R1 default sel", count, 1);

    for (int s = 0; s < 4; s++) begin
      do_reset();
      wr(0, 0, s);
      for (int t = 0; t < 4; t++) pulse(t, t + 1);
      chk($sformatf("R2 sel %0d", s), count, s + 1);
    end

    for (int pm = 0; pm < 6; pm++) begin
      do_reset();
      wr(0, 0, 0);
      pwr_mode = 3'(pm);
      pulse(0, 5);
      chk($sformatf("R8 pmode %0d", pm), count, pm <= 1 ? 5 : 0);
    end

    for (int pm = 0; pm < 6; pm++) begin
      do_reset();
      wr(1, 0, 3);
      pwr_mode = 3'(pm);
      subs(13, 3);
      chk($sformatf("R9 pmode %0d", pm), count, pm <= 4 ? 3 : 0);
      pwr_mode = 3'd0;
      subs(3, 3);
      chk($sformatf("R9 resume %0d", pm), count, pm <= 4 ? 4 : 0);
    end

    for (int s = 0; s < 3; s++) begin
      int div;
      div = 1 << (7 - s);
      do_reset();
      wr(1, 0, s);
      subs(div - 1, 3);
      chk($sformatf("R3 sel %0d before", s), count, 0);
      subs(1, 3);
      chk($sformatf("R3 sel %0d first", s), count, 1);
      subs(div + div / 2, 3);
      chk($sformatf("R3 sel %0d second", s), count, 2);
    end

    do_reset();
    wr(1, 0, 3);
    subs(1020, 3);
    chk("R3 sel 3 count", count, 255);
    chk("R7 flag before wrap", ovf_flag, 0);
    subs(4, 3);
    chk("R7 R10 wrap count", count, 0);
    chk("R7 wrap flag", ovf_flag, 1);

    do_reset();
    pulse(0, 255);
    chk("R10 at max", count, 255);
    chk("R7 no flag", ovf_flag, 0);
    pulse(0, 1);
    chk("R10 wrap", count, 0);
    chk("R7 set", ovf_flag, 1);
    pulse(0, 3);
    chk("R7 sticky", ovf_flag, 1);
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
    chk("R7 cleared", ovf_flag, 0);
    pulse(0, 252);
    @(negedge clk); sys_ticks = 4'b0001; flag_clr = 1'b1;
    @(negedge clk); sys_ticks = '0; flag_clr = 1'b0;
    chk("R7 set wins", ovf_flag, 1);

    do_reset();
    wr(1, 0, 3);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); sub_clk = 1'b1;
      repeat (40) @(negedge clk);
      sub_clk = 1'b0;
      repeat (40) @(negedge clk);
    end
    chk("R4 long pulses", count, 1);

    do_reset();
    wr(1, 0, 2);
    subs(40, 3);
    chk("R5 pre", count, 1);
    wr(1, 1, 2);
    chk("R5 cleared", count, 0);
    subs(31, 3);
    chk("R5 prescaler cleared", count, 0);
    subs(1, 3);
    chk("R5 restart", count, 1);

    do_reset();
    pulse(0, 7);
    wr(0, 1, 0);
    chk("R6 no clear", count, 7);
    pulse(0, 1);
    chk("R6 still counts", count, 8);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule